// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It has two sources: an external event pulse and a timer overflow pulse. Each source sets a request flag in an 8-bit control/status register. Software reads and writes that register over a simple register bus. The same register holds a global enable and one enable per source.

Requests are only evaluated in a cycle marked by the T2 phase strobe. A request is taken when the global enable, its own enable and its flag are all set and the core's call stack is not full. The block then raises a one-cycle take strobe with the vector address. On acceptance it clears the serviced flag and the global enable. A return-from-interrupt strobe sets the global enable again. A plain return strobe leaves the register untouched.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Register bit positions are: global enable 0, external enable 1, timer enable 2, external flag 4, timer flag 5. Bits 3, 6 and 7 always read 0, so writing 8'hFF reads back 8'h37.
- R2: An `ext_evt` pulse sets bit 4 and a `tmr_ovf` pulse sets bit 5. The bit is visible on `csr_rdata` the cycle after the pulse.
- R3: A request is accepted only when bit 0, its own enable and its flag are set, `stack_full` is low and no register write occurs in that cycle.
- R4: The external source takes vector 8'h04 and the timer source takes vector 8'h08.
- R5: When both sources are ready in the same evaluation, the external source is taken.
- R6: On acceptance, the serviced flag and bit 0 are cleared. The other flag keeps its value.
- R7: A flag stays set while it is disabled or blocked. It is cleared only by acceptance or by a software write.
- R8: `reti_stb` sets bit 0. `ret_stb` changes no register bit.
- R9: Requests are evaluated only in cycles with `t2_stb` high. A flag that is set by a pulse in the same cycle as one T2 strobe is serviced at the following T2 strobe.
- R10: After reset, the register reads 8'h00, `take_stb` is low and `take_vec` is 8'h00.
- R11: A software write overrides a hardware flag set in the same cycle. A hardware set in the cycle after the write is kept.
- R12: `take_stb` is high for exactly one cycle, in the cycle after the T2 strobe that accepted the request. `take_vec` carries the vector while the strobe is high and reads 8'h00 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t2_stb | input | 1 | T2 phase strobe; requests are evaluated in this cycle |
| stack_full | input | 1 | Call stack has no free entry |
| ext_evt | input | 1 | External interrupt event pulse |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ret_stb | input | 1 | Plain return executed |
| reti_stb | input | 1 | Return-from-interrupt executed |
| csr_wr | input | 1 | Register write enable |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| take_stb | output | 1 | One-cycle interrupt take strobe |
| take_vec | output | 8 | Vector address of the taken interrupt |

## Verification
Register effects from events, writes, returns and acceptance show on `csr_rdata` one cycle after the stimulus. The take strobe and vector appear one cycle after the accepting T2 strobe, and the strobe is low again in the cycle after that. The driver changes inputs on falling edges. Each stimulus lasts exactly one rising edge, and register values are read at the next falling edge. Expected vectors go into a queue before the T2 strobe is driven. A monitor pops the queue at the falling edge that follows each strobe. It treats any strobe with nothing queued, and any strobe lasting two cycles, as a failure.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int CSR_W  = 8;
  localparam int B_GIE  = 0;
  localparam int B_XEN  = 1;
  localparam int B_TEN  = 2;
  localparam int B_XFLG = 4;
  localparam int B_TFLG = 5;

  localparam logic [CSR_W-1:0] CSR_LIVE =
    CSR_W'((1 << B_GIE) | (1 << B_XEN) | (1 << B_TEN) | (1 << B_XFLG) | (1 << B_TFLG));

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR  = 2'd2
  } irq_src_e;

  // Fixed priority: external before timer.
  function automatic irq_src_e pick_src(input logic x_rdy, input logic t_rdy);
    if (x_rdy)      return SRC_EXT;
    else if (t_rdy) return SRC_TMR;
    else            return SRC_NONE;
  endfunction

  function automatic logic [CSR_W-1:0] src_vec(input irq_src_e s,
                                               input logic [CSR_W-1:0] xv,
                                               input logic [CSR_W-1:0] tv);
    case (s)
      SRC_EXT: return xv;
      SRC_TMR: return tv;
      default: return '0;
    endcase
  endfunction

  // A source is ready when global enable, its enable and its flag are all set.
  function automatic logic src_ready(input logic [CSR_W-1:0] q, input int en_b, input int fl_b);
    return q[B_GIE] & q[en_b] & q[fl_b];
  endfunction

endpackage

// File: rtl/irq_csr.sv
module irq_csr
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wdata,
  input  logic             ext_set,
  input  logic             tmr_set,
  input  logic             gie_set,
  input  logic             ack_ext,
  input  logic             ack_tmr,
  output logic [CSR_W-1:0] csr_q
);

  logic [CSR_W-1:0] csr_d;

  // Update order, lowest priority first: return, acceptance, hw set, sw write.
  always_comb begin
    csr_d = csr_q;
    if (gie_set)           csr_d[B_GIE]  = 1'b1;
    if (ack_ext | ack_tmr) csr_d[B_GIE]  = 1'b0;
    if (ack_ext)           csr_d[B_XFLG] = 1'b0;
    if (ack_tmr)           csr_d[B_TFLG] = 1'b0;
    if (ext_set)           csr_d[B_XFLG] = 1'b1;
    if (tmr_set)           csr_d[B_TFLG] = 1'b1;
    if (wr_en)             csr_d         = wdata;
    csr_d = csr_d & CSR_LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d;
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_vec_pkg::*;
#(
  parameter logic [CSR_W-1:0] EXT_VEC = 8'h04,
  parameter logic [CSR_W-1:0] TMR_VEC = 8'h08
) (
  input  logic [CSR_W-1:0] csr_q,
  input  logic             t2_stb,
  input  logic             stack_full,
  input  logic             wr_en,
  output logic             ext_ready,
  output logic             tmr_ready,
  output logic             ack_ext,
  output logic             ack_tmr,
  output logic [CSR_W-1:0] vec
);

  irq_src_e win;
  logic     eval;

  assign ext_ready = src_ready(csr_q, B_XEN, B_XFLG);
  assign tmr_ready = src_ready(csr_q, B_TEN, B_TFLG);
  assign eval      = t2_stb & ~stack_full & ~wr_en;

  always_comb begin
    win = eval ? pick_src(ext_ready, tmr_ready) : SRC_NONE;
  end

  assign ack_ext = (win == SRC_EXT);
  assign ack_tmr = (win == SRC_TMR);
  assign vec     = src_vec(win, EXT_VEC, TMR_VEC);

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter logic [CSR_W-1:0] EXT_VEC = 8'h04,
  parameter logic [CSR_W-1:0] TMR_VEC = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             t2_stb,
  input  logic             stack_full,
  input  logic             ext_evt,
  input  logic             tmr_ovf,
  input  logic             ret_stb,
  input  logic             reti_stb,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             take_stb,
  output logic [CSR_W-1:0] take_vec
);

  logic [CSR_W-1:0] csr_q;
  logic             ext_ready, tmr_ready;
  logic             ack_ext, ack_tmr, ack_any;
  logic [CSR_W-1:0] pick_vec;
  logic             plain_ret;

  // Named event for the checker: a return that must not touch the register.
  assign plain_ret = ret_stb & ~reti_stb;

  irq_csr u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (csr_wr),
    .wdata   (csr_wdata),
    .ext_set (ext_evt),
    .tmr_set (tmr_ovf),
    .gie_set (reti_stb),
    .ack_ext (ack_ext),
    .ack_tmr (ack_tmr),
    .csr_q   (csr_q)
  );

  irq_pick #(.EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) u_pick (
    .csr_q      (csr_q),
    .t2_stb     (t2_stb),
    .stack_full (stack_full),
    .wr_en      (csr_wr),
    .ext_ready  (ext_ready),
    .tmr_ready  (tmr_ready),
    .ack_ext    (ack_ext),
    .ack_tmr    (ack_tmr),
    .vec        (pick_vec)
  );

  assign ack_any = ack_ext | ack_tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_stb <= 1'b0;
      take_vec <= '0;
    end else begin
      take_stb <= ack_any;
      take_vec <= pick_vec;
    end
  end

  assign csr_rdata = csr_q;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_vec_pkg::*;
#(
  parameter logic [CSR_W-1:0] EXT_VEC = 8'h04,
  parameter logic [CSR_W-1:0] TMR_VEC = 8'h08
) (
  input logic             clk,
  input logic             rst_n,
  input logic             t2_stb,
  input logic             stack_full,
  input logic             ext_evt,
  input logic             tmr_ovf,
  input logic             reti_stb,
  input logic             plain_ret,
  input logic             csr_wr,
  input logic [CSR_W-1:0] csr_rdata,
  input logic             ext_ready,
  input logic             take_stb,
  input logic [CSR_W-1:0] take_vec
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~CSR_LIVE) == '0); // R1

  AST_EXT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ext_evt && !csr_wr) |-> csr_rdata[B_XFLG]); // R2

  AST_TMR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(tmr_ovf && !csr_wr) |-> csr_rdata[B_TFLG]); // R2

  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    armed && take_stb |-> $past(t2_stb && !stack_full && !csr_wr)); // R3

  AST_TAKE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |-> (take_vec == EXT_VEC || take_vec == TMR_VEC)); // R4

  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    armed && take_stb && $past(ext_ready) |-> take_vec == EXT_VEC); // R5

  AST_ACK_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |-> !csr_rdata[B_GIE]); // R6

  AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(reti_stb && !csr_wr) && !take_stb |-> csr_rdata[B_GIE]); // R8

  AST_RET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(plain_ret && !csr_wr && !ext_evt && !tmr_ovf && !t2_stb)
      |-> $stable(csr_rdata)); // R8

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |=> !take_stb); // R12

  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !take_stb |-> take_vec == '0); // R12

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .t2_stb     (t2_stb),
  .stack_full (stack_full),
  .ext_evt    (ext_evt),
  .tmr_ovf    (tmr_ovf),
  .reti_stb   (reti_stb),
  .plain_ret  (plain_ret),
  .csr_wr     (csr_wr),
  .csr_rdata  (csr_rdata),
  .ext_ready  (ext_ready),
  .take_stb   (take_stb),
  .take_vec   (take_vec)
);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       t2_stb = 0, stack_full = 0, ext_evt = 0, tmr_ovf = 0;
  logic       ret_stb = 0, reti_stb = 0, csr_wr = 0;
  logic [7:0] csr_wdata = 0;
  logic [7:0] csr_rdata;
  logic       take_stb;
  logic [7:0] take_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  localparam logic [7:0] V_EXT = 8'h04;
  localparam logic [7:0] V_TMR = 8'h08;

  always #10 clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .t2_stb(t2_stb), .stack_full(stack_full),
    .ext_evt(ext_evt), .tmr_ovf(tmr_ovf), .ret_stb(ret_stb), .reti_stb(reti_stb),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .take_stb(take_stb), .take_vec(take_vec)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One stimulus cycle: inputs set after a falling edge, held over one rising edge.
  task automatic step(input logic e, input logic t, input logic t2,
                      input logic rt, input logic rti, input logic wr,
                      input logic [7:0] wd);
    ext_evt = e; tmr_ovf = t; t2_stb = t2; ret_stb = rt; reti_stb = rti;
    csr_wr = wr; csr_wdata = wd;
    @(negedge clk);
    ext_evt = 0; tmr_ovf = 0; t2_stb = 0; ret_stb = 0; reti_stb = 0;
    csr_wr = 0; csr_wdata = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    step(0, 0, 0, 0, 0, 1, d);
  endtask

  // Driver: queue the expected vector (if any), then drive the T2 strobe.
  task automatic t2(input bit expect_take, input logic [7:0] v);
    if (expect_take) exp_q.push_back(v);
    step(0, 0, 1, 0, 0, 0, 8'h00);
  endtask

  // Monitor: every take is compared with the queue; strobe width is checked.
  initial begin
    logic prev;
    prev = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (take_stb) begin
          if (exp_q.size() == 0) chk("R3 unexpected take", 8'h01, 8'h00);
          else chk("R4 R5 vector", take_vec, exp_q.pop_front());
          chk("R12 strobe width", {7'd0, prev}, 8'h00);
        end else begin
          if (prev) chk("R12 idle vector", take_vec, 8'h00);
        end
        prev = take_stb;
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset csr", csr_rdata, 8'h00);
    chk("R10 reset take", {7'd0, take_stb}, 8'h00);
    chk("R10 reset vec", take_vec, 8'h00);
    rst_n = 1;
    @(negedge clk);

    wr(8'hFF);
    chk("R1 live bits", csr_rdata, 8'h37);
    wr(8'h00);
    chk("R1 clear", csr_rdata, 8'h00);

    step(1, 0, 0, 0, 0, 0, 8'h00);
    chk("R2 ext flag", csr_rdata, 8'h10);
    step(0, 1, 0, 0, 0, 0, 8'h00);
    chk("R2 tmr flag", csr_rdata, 8'h30);
    t2(0, 8'h00);
    @(negedge clk);
    chk("R7 flags kept while disabled", csr_rdata, 8'h30);

    wr(8'h37);
    stack_full = 1;
    t2(0, 8'h00);
    @(negedge clk);
    chk("R3 stack full blocks", csr_rdata, 8'h37);
    stack_full = 0;

    t2(1, V_EXT);
    chk("R6 ext ack clears flag and gie", csr_rdata, 8'h26);
    @(negedge clk);

    step(0, 0, 0, 1, 0, 0, 8'h00);
    chk("R8 ret no effect", csr_rdata, 8'h26);
    t2(0, 8'h00);
    @(negedge clk);
    step(0, 0, 0, 0, 1, 0, 8'h00);
    chk("R8 reti sets gie", csr_rdata, 8'h27);
    t2(1, V_TMR);
    chk("R6 tmr ack", csr_rdata, 8'h06);
    @(negedge clk);

    wr(8'h03);
    step(1, 0, 1, 0, 0, 0, 8'h00);
    chk("R9 flag set on T2 cycle, no take yet", csr_rdata, 8'h13);
    step(0, 0, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 0, 0, 8'h00);
    chk("R9 no take between T2", csr_rdata, 8'h13);
    t2(1, V_EXT);
    chk("R9 served on next T2", csr_rdata, 8'h02);
    @(negedge clk);

    step(1, 0, 0, 0, 0, 1, 8'h00);
    chk("R11 write beats hw set", csr_rdata, 8'h00);
    step(1, 0, 0, 0, 0, 0, 8'h00);
    chk("R11 next-cycle set kept", csr_rdata, 8'h10);
    wr(8'h13);
    step(0, 0, 1, 0, 0, 1, 8'h13);
    @(negedge clk);
    chk("R3 write cycle blocks take", csr_rdata, 8'h13);
    t2(1, V_EXT);
    chk("R12 take cleared state", csr_rdata, 8'h02);
    repeat (2) @(negedge clk);

    chk("R12 all expected takes seen", 8'(exp_q.size()), 8'h00);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule